// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time

This block produces the four gate commands of one full bridge: a high-side and a low-side switch for each of the two output legs. It decodes an enable and two direction inputs into one of five bridge modes: disabled, brake through the low side, forward, reverse and brake through the high side. A chop request from an external current regulator turns the forward and reverse modes into slow decay. During a chop, the leg that is sinking current hands its conduction from the low-side switch to its high-side partner. The load current then recirculates through the two high-side switches.

Each leg has its own sequencer. A switch that must turn off does so at the next clock edge. A switch that must turn on waits until its leg has held both gates low for `DEAD_CYC` consecutive cycles. No two switches of one leg ever conduct together, whatever the inputs do: mode changes, chop edges and short chop pulses all follow the same order. The switch breaks first, the dead time runs, and then the other switch makes. Leg index 0 drives output 1 and leg index 1 drives output 2.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While `en` is 0, all four gate outputs go to 0 at the next clock edge and stay 0, whatever `dir1`, `dir2` and `chop` do.
- R2: With `en`=1, `dir1`=0 and `dir2`=0, both low-side gates settle to 1 and both high-side gates to 0 (`hs_gate`=2'b00, `ls_gate`=2'b11).
- R3: With `en`=1, `dir1`=1 and `dir2`=0 (forward), the gates settle to `hs_gate`=2'b01 and `ls_gate`=2'b10. While `chop`=1, leg 1 swaps its low-side gate for its high-side gate (`hs_gate`=2'b11, `ls_gate`=2'b00), and `hs_gate[0]` stays 1 throughout.
- R4: With `en`=1, `dir1`=0 and `dir2`=1 (reverse), the gates settle to `hs_gate`=2'b10 and `ls_gate`=2'b01. While `chop`=1, leg 0 swaps its low-side gate for its high-side gate (`hs_gate`=2'b11, `ls_gate`=2'b00).
- R5: With `en`=1, `dir1`=1 and `dir2`=1, both high-side gates settle to 1 and both low-side gates to 0. In both brake modes `chop` has no effect on the gates.
- R6: A gate whose switch is no longer requested drops at the first clock edge after the inputs change.
- R7: A gate rises only after its leg has had both gates at 0 for `DEAD_CYC` consecutive cycles. A break followed by a make therefore takes `DEAD_CYC`+1 edges from the input change. A leg that has already been idle that long turns on at the next edge.
- R8: When `chop` returns to 0 in forward or reverse, the rectifying high-side gate drops at the next edge and the low-side gate returns `DEAD_CYC` cycles later. A chop pulse shorter than the dead time never raises the high-side gate.
- R9: The high-side and low-side gate of one leg are never 1 in the same cycle.
- R10: Switching directly from forward to reverse breaks both legs at the next edge. Each leg then makes its new switch after the dead time.
- R11: During and after reset all gates are 0. The first turn-on after reset happens `DEAD_CYC` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Bridge enable; 0 turns every switch off |
| dir1 | input | 1 | Direction input 1 |
| dir2 | input | 1 | Direction input 2 |
| chop | input | 1 | Off-time request from the current regulator |
| hs_gate | output | 2 | High-side gate per leg, bit 0 = output 1 |
| ls_gate | output | 2 | Low-side gate per leg, bit 0 = output 1 |

## Verification
The bench counts clock edges from each input change to each gate rise. A design whose dead-time counter is off by one shows up with a gap of `DEAD_CYC` or `DEAD_CYC`+2 edges, and a design that makes before it breaks shows shoot-through in the per-cycle overlap monitor. A chop pulse shorter than the dead time is applied to catch a sequencer that commits to the high side once it has started counting. A direct forward-to-reverse swap is applied to catch a sequencer that skips the idle gap when the target changes. The bench also drives chop in both brake modes and toggles the direction inputs while disabled. These stimuli expose decoders that let chop or direction leak into modes where they must be ignored.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [2:0] {
        MODE_OFF,
        MODE_BRAKE_LO,
        MODE_FWD,
        MODE_REV,
        MODE_BRAKE_HI
    } bridge_mode_t;

    typedef enum logic [1:0] {
        WANT_NONE,
        WANT_HI,
        WANT_LO
    } leg_want_t;

    localparam int NUM_LEGS = 2;

    function automatic bridge_mode_t mode_of(input logic en, input logic d1, input logic d2);
        if (!en)
            return MODE_OFF;
        case ({d1, d2})
            2'b00:   return MODE_BRAKE_LO;
            2'b10:   return MODE_FWD;
            2'b01:   return MODE_REV;
            default: return MODE_BRAKE_HI;
        endcase
    endfunction

endpackage

// File: rtl/hbg_decode.sv
module hbg_decode
    import hbg_pkg::*;
(
    input  logic                      en,
    input  logic                      dir1,
    input  logic                      dir2,
    input  logic                      chop,
    output leg_want_t [NUM_LEGS-1:0]  want
);

    bridge_mode_t mode;

    always_comb begin
        mode = mode_of(en, dir1, dir2);
        want = {WANT_NONE, WANT_NONE};
        case (mode)
            MODE_BRAKE_LO: begin
                want[0] = WANT_LO;
                want[1] = WANT_LO;
            end
            MODE_BRAKE_HI: begin
                want[0] = WANT_HI;
                want[1] = WANT_HI;
            end
            MODE_FWD: begin
                want[0] = WANT_HI;
                want[1] = chop ? WANT_HI : WANT_LO;
            end
            MODE_REV: begin
                want[0] = chop ? WANT_HI : WANT_LO;
                want[1] = WANT_HI;
            end
            default: begin
                want[0] = WANT_NONE;
                want[1] = WANT_NONE;
            end
        endcase
    end

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  leg_want_t want,
    output logic      hi,
    output logic      lo
);

    localparam int          CW   = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] FULL = CW'(DEAD_CYC);

    logic          hi_q, lo_q, hi_d, lo_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        hi_d  = hi_q;
        lo_d  = lo_q;
        cnt_d = cnt_q;
        if (hi_q || lo_q) begin
            if (!((want == WANT_HI && hi_q) || (want == WANT_LO && lo_q))) begin
                hi_d  = 1'b0;
                lo_d  = 1'b0;
                cnt_d = '0;
            end
        end else if (want != WANT_NONE && cnt_q == LAST) begin
            hi_d = (want == WANT_HI);
            lo_d = (want == WANT_LO);
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= 1'b0;
            lo_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            hi_q  <= hi_d;
            lo_q  <= lo_d;
            cnt_q <= cnt_d;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

    // Independent count of idle cycles, used only by the checks below
    logic [CW-1:0] idle_run_q;
    always_ff @(posedge clk) begin
        if (rst)
            idle_run_q <= '0;
        else if (hi_q || lo_q)
            idle_run_q <= '0;
        else if (idle_run_q != FULL)
            idle_run_q <= idle_run_q + 1'b1;
    end

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(hi_q && lo_q));

    // R7
    hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_q) |-> idle_run_q == FULL);

    // R7
    lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_q) |-> idle_run_q == FULL);

    // R6
    hi_break_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_q && want != WANT_HI) |=> !hi_q);

    // R6
    lo_break_chk: assert property (@(posedge clk) disable iff (rst)
        (lo_q && want != WANT_LO) |=> !lo_q);

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       dir1,
    input  logic       dir2,
    input  logic       chop,
    output logic [1:0] hs_gate,
    output logic [1:0] ls_gate
);

    leg_want_t [NUM_LEGS-1:0] want;

    hbg_decode u_decode (
        .en   (en),
        .dir1 (dir1),
        .dir2 (dir2),
        .chop (chop),
        .want (want)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk  (clk),
            .rst  (rst),
            .want (want[g]),
            .hi   (hs_gate[g]),
            .lo   (ls_gate[g])
        );
    end

    // R1
    disable_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (hs_gate == 2'b00 && ls_gate == 2'b00));

    // R5
    brake_hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir1 && dir2 && hs_gate == 2'b11) |=> hs_gate == 2'b11);

endmodule

// File: tb/hbridge_gate_seq_test.sv
module hbridge_gate_seq_test;

    localparam int DEAD = 10;

    logic       clk = 1'b0;
    logic       rst, en, dir1, dir2, chop;
    logic [1:0] hs_gate, ls_gate;

    int checks = 0;
    int errors = 0;
    int overlap = 0;

    hbridge_gate_seq #(.DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst(rst), .en(en), .dir1(dir1), .dir2(dir2), .chop(chop),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk)
        if (!rst && ((hs_gate[0] && ls_gate[0]) || (hs_gate[1] && ls_gate[1])))
            overlap++;

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_gates(input string req, input logic [1:0] ehs, input logic [1:0] els);
        checks++;
        if (hs_gate !== ehs || ls_gate !== els) begin
            errors++;
            $display("FAIL %s: actual hs=%b ls=%b expected hs=%b ls=%b",
                     req, hs_gate, ls_gate, ehs, els);
        end
    endtask

    task automatic apply(input logic e, input logic a, input logic b, input logic c);
        @(negedge clk);
        en = e; dir1 = a; dir2 = b; chop = c;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // edges from the preceding apply until the chosen gate reads 1
    task automatic edges_to(input int leg, input bit hi_side, output int n);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (hi_side ? hs_gate[leg] : ls_gate[leg]) break;
        end
    endtask

    task automatic t_reset;
        int n;
        rst = 1'b1; en = 1'b0; dir1 = 1'b0; dir2 = 1'b0; chop = 1'b0;
        step(4);
        check_gates("R11 reset state", 2'b00, 2'b00);
        @(negedge clk);
        rst = 1'b0; en = 1'b1; dir1 = 1'b1;
        edges_to(0, 1'b1, n);
        check_int("R11 first turn-on after reset", n, DEAD);
        check_gates("R3 forward settled", 2'b01, 2'b10);
    endtask

    task automatic t_fwd_chop;
        int n;
        apply(1, 1, 0, 1);
        step(1);
        check_gates("R6 low side breaks at once", 2'b01, 2'b00);
        edges_to(1, 1'b1, n);
        check_int("R7 chop make after dead time", n + 1, DEAD + 1);
        check_gates("R3 forward chop rectifying", 2'b11, 2'b00);
        apply(1, 1, 0, 0);
        step(1);
        check_gates("R8 high side breaks at chop end", 2'b01, 2'b00);
        edges_to(1, 1'b0, n);
        check_int("R8 low side returns after dead time", n + 1, DEAD + 1);
        check_gates("R3 forward after chop", 2'b01, 2'b10);
    endtask

    task automatic t_short_chop;
        int n;
        int hi_seen = 0;
        apply(1, 1, 0, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (hs_gate[1]) hi_seen++;
        end
        chop = 1'b0;
        n = 3;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (hs_gate[1]) hi_seen++;
            if (ls_gate[1]) break;
        end
        check_int("R8 short chop never raises high side", hi_seen, 0);
        check_int("R7 short chop low side return", n, DEAD + 1);
    endtask

    task automatic t_reverse;
        int n;
        apply(1, 0, 1, 0);
        step(1);
        check_gates("R10 both legs break", 2'b00, 2'b00);
        edges_to(0, 1'b0, n);
        check_int("R10 make after dead time", n + 1, DEAD + 1);
        check_gates("R4 reverse settled", 2'b10, 2'b01);
        apply(1, 0, 1, 1);
        step(DEAD + 3);
        check_gates("R4 reverse chop rectifying", 2'b11, 2'b00);
    endtask

    task automatic t_brakes;
        apply(1, 0, 0, 0);
        step(DEAD + 3);
        check_gates("R2 brake low", 2'b00, 2'b11);
        apply(1, 0, 0, 1);
        step(DEAD + 3);
        check_gates("R5 chop ignored in brake low", 2'b00, 2'b11);
        apply(1, 1, 1, 0);
        step(DEAD + 3);
        check_gates("R5 brake high", 2'b11, 2'b00);
        apply(1, 1, 1, 1);
        step(DEAD + 3);
        check_gates("R5 chop ignored in brake high", 2'b11, 2'b00);
    endtask

    task automatic t_disable;
        int n;
        apply(0, 1, 1, 1);
        step(1);
        check_gates("R1 disable at next edge", 2'b00, 2'b00);
        apply(0, 1, 0, 0);
        step(3);
        apply(0, 0, 1, 1);
        step(DEAD + 3);
        check_gates("R1 directions ignored while disabled", 2'b00, 2'b00);
        apply(1, 1, 0, 0);
        edges_to(0, 1'b1, n);
        check_int("R7 idle leg turns on at next edge", n, 1);
        check_gates("R3 forward after re-enable", 2'b01, 2'b10);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fwd_chop();
        t_short_chop();
        t_reverse();
        t_brakes();
        t_disable();
        check_int("R9 no overlap in any leg", overlap, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule